// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a core's load/store stage and a byte-addressed memory whose data bus is several bytes wide. For a store it takes the address, an access size and the register operand. It returns a per-byte write-enable mask and the operand moved onto the correct byte lanes. The lane order is big-endian: byte offset 0 lives in the most significant lane and is enabled by the top mask bit. For a load it takes the word read from memory and returns the addressed byte or halfword, extended with sign or zeros, or the full word.

Misalignment does not trap. An access is misaligned when a word address has any low offset bit set, or when a halfword address is odd. The unit then clears those low address bits and lets the access go ahead. It also records the event in a two-bit sticky bitmap and latches the original faulting address. At the end of each instruction the core reads the bitmap and address and pulses a clear input. An unsupported size code produces no enables and raises an error flag. The data path is combinational; only the fault record is registered.

Top module: `be_lane_unit`

## Requirements
- R1: A word access (size code 2) drives mem_be = 4'hF and passes st_data unchanged to mem_wdata.
- R2: A halfword access (size code 1) at address bit 1 = 0 drives mem_be = 4'hC with st_data[15:0] in mem_wdata[31:16]. At address bit 1 = 1 it drives mem_be = 4'h3 with st_data[15:0] in mem_wdata[15:0]. All other write-data bits are zero.
- R3: A byte access (size code 0) at byte offset 0, 1, 2 or 3 drives mem_be = 4'h8, 4'h4, 4'h2 or 4'h1. st_data[7:0] sits in bits 31:24, 23:16, 15:8 or 7:0 respectively, and the other bits are zero.
- R4: misalign is high, in the same cycle, for a valid word access with acc_addr[1:0] nonzero or a valid halfword access with acc_addr[0] = 1. Byte accesses are never misaligned.
- R5: mem_addr equals acc_addr with bits 1:0 cleared for word accesses and bit 0 cleared for halfword accesses, and equals acc_addr otherwise. Lane selection, mask and load extraction all use this corrected address.
- R6: One cycle after a valid misaligned read, fault_map bit 0 is set. One cycle after a valid misaligned write, fault_map bit 1 is set. Both bits stay set until cleared.
- R7: One cycle after any valid misaligned access, fault_addr holds that access's uncorrected acc_addr, so it always shows the most recent fault. Otherwise fault_addr holds its value.
- R8: fault_clear empties fault_map on the next edge. A misaligned access in the same cycle as fault_clear still sets its bit.
- R9: Loads return, from the lanes of R1–R3: size 0 with acc_signed = 1 gives a sign-extended byte, and with acc_signed = 0 a zero-extended byte. Size 1 gives a halfword extended the same way. Size 2 gives ld_word unchanged.
- R10: Size code 3 with acc_valid high gives mem_be = 0, mem_wdata = 0, ld_data = 0, size_err = 1, and records no fault.
- R11: With acc_valid low, mem_be, mem_wdata, size_err and misalign are zero and no fault is recorded, whatever the address.
- R12: During and right after reset, fault_map and fault_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| acc_signed | input | 1 | Sign-extend sub-word loads |
| acc_addr | input | ADDR_W | Byte address from the core |
| st_data | input | DATA_W | Store operand, right-justified |
| ld_word | input | DATA_W | Word returned by memory |
| fault_clear | input | 1 | End-of-instruction clear of the fault bitmap |
| mem_addr | output | ADDR_W | Corrected address to memory |
| mem_be | output | DATA_W/8 | Byte enables, MSB = byte offset 0 |
| mem_wdata | output | DATA_W | Lane-aligned write data |
| ld_data | output | DATA_W | Extracted, extended load result |
| misalign | output | 1 | Current access is misaligned |
| size_err | output | 1 | Current access has an unsupported size |
| fault_map | output | 2 | Sticky faults: bit 0 read, bit 1 write |
| fault_addr | output | ADDR_W | Address of the most recent misaligned access |

## Verification
The embedded assertions check the following on every cycle:
- enables are zero when idle or for the unsupported size;
- byte accesses enable exactly one lane;
- word addresses leave the unit aligned;
- fault bits stay set until a clear;
- a misaligned access is captured with its address on the next edge;
- a clear with no new fault empties the map.

Only the bench's scenarios show the exact lane placement at each offset, the sign and zero extension of loads, and the rule that a fault beats a clear in the same cycle. They also show that the latched address follows the latest of several faults. The bench's reference model predicts every output from the requirements and compares it on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } lsu_size_e;

   localparam int unsigned FAULT_RD_BIT = 0;
   localparam int unsigned FAULT_WR_BIT = 1;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 2
) (
   input  logic              valid,
   input  lsu_size_e         size,
   input  logic [ADDR_W-1:0] addr,
   output logic              misaligned,
   output logic              size_bad,
   output logic [ADDR_W-1:0] addr_fixed
);

   logic half_odd;
   logic word_off;

   assign half_odd = addr[0];
   assign word_off = |addr[OFF_W-1:0];

   always_comb begin
      addr_fixed = addr;
      unique case (size)
         SZ_HALF: addr_fixed[0] = 1'b0;
         SZ_WORD: addr_fixed[OFF_W-1:0] = '0;
         default: addr_fixed = addr;
      endcase
   end

   assign misaligned = valid && (((size == SZ_HALF) && half_odd) ||
                                 ((size == SZ_WORD) && word_off));
   assign size_bad   = (size == SZ_BAD);

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned OFF_W = $clog2(LANES)
) (
   input  logic              en,
   input  lsu_size_e         size,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] lane_data
);

   // Lane g holds byte offset LANES-1-g (big-endian).
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned BOFF = LANES - 1 - g;
      localparam logic [OFF_W-1:0] BOFF_V = OFF_W'(BOFF);
      logic hit;
      logic [7:0] byte_src;

      always_comb begin
         hit      = 1'b0;
         byte_src = 8'h00;
         unique case (size)
            SZ_BYTE: begin
               hit      = (off == BOFF_V);
               byte_src = wdata[7:0];
            end
            SZ_HALF: begin
               hit      = (off[OFF_W-1:1] == BOFF_V[OFF_W-1:1]);
               byte_src = (BOFF % 2 == 0) ? wdata[15:8] : wdata[7:0];
            end
            SZ_WORD: begin
               hit      = 1'b1;
               byte_src = wdata[8*g +: 8];
            end
            default: begin
               hit      = 1'b0;
               byte_src = 8'h00;
            end
         endcase
      end

      assign be[g]             = en && hit;
      assign lane_data[8*g +: 8] = be[g] ? byte_src : 8'h00;
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned HALVES = LANES / 2,
   localparam int unsigned OFF_W = $clog2(LANES)
) (
   input  lsu_size_e         size,
   input  logic              sext,
   input  logic [OFF_W-1:0]  off,
   input  logic [DATA_W-1:0] rword,
   output logic [DATA_W-1:0] rdata
);

   logic [7:0]  byte_at [LANES];
   logic [15:0] half_at [HALVES];

   for (genvar o = 0; o < LANES; o++) begin : g_byte
      assign byte_at[o] = rword[DATA_W-1-8*o -: 8];
   end
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign half_at[h] = rword[DATA_W-1-16*h -: 16];
   end

   logic [7:0]  b_sel;
   logic [15:0] h_sel;

   assign b_sel = byte_at[off];
   assign h_sel = half_at[off[OFF_W-1:1]];

   always_comb begin
      unique case (size)
         SZ_BYTE: rdata = {{(DATA_W-8){sext & b_sel[7]}}, b_sel};
         SZ_HALF: rdata = {{(DATA_W-16){sext & h_sel[15]}}, h_sel};
         SZ_WORD: rdata = rword;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/lsu_fault_log.sv
module lsu_fault_log
   import lsu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fault,
   input  logic              wr_fault,
   input  logic              clear,
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        fault_map,
   output logic [ADDR_W-1:0] fault_addr
);

   logic [1:0] map_next;

   always_comb begin
      map_next = clear ? 2'b00 : fault_map;
      if (rd_fault) map_next[FAULT_RD_BIT] = 1'b1;
      if (wr_fault) map_next[FAULT_WR_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_map  <= 2'b00;
         fault_addr <= '0;
      end else begin
         fault_map <= map_next;
         if (rd_fault || wr_fault) fault_addr <= addr;
      end
   end

   AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault_map[FAULT_RD_BIT] && !clear |=> fault_map[FAULT_RD_BIT]); // R6
   AST_WR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault_map[FAULT_WR_BIT] && !clear |=> fault_map[FAULT_WR_BIT]); // R6
   AST_CAPTURE_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fault |=> fault_map[FAULT_RD_BIT] && (fault_addr == $past(addr))); // R7
   AST_CAPTURE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fault |=> fault_map[FAULT_WR_BIT] && (fault_addr == $past(addr))); // R7
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clear && !rd_fault && !wr_fault |=> fault_map == 2'b00); // R8

endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
   import lsu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [1:0]            acc_size,
   input  logic                  acc_signed,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [DATA_W-1:0]     st_data,
   input  logic [DATA_W-1:0]     ld_word,
   input  logic                  fault_clear,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W/8-1:0]   mem_be,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W-1:0]     ld_data,
   output logic                  misalign,
   output logic                  size_err,
   output logic [1:0]            fault_map,
   output logic [ADDR_W-1:0]     fault_addr
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(LANES);

   if ((DATA_W % 16) != 0 || LANES < 4) begin : g_bad_width
      $error("be_lane_unit: DATA_W must be a multiple of 16 and at least 32");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("be_lane_unit: DATA_W/8 must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("be_lane_unit: ADDR_W too small for the lane offset");
   end

   lsu_size_e         size;
   logic              mis_w;
   logic              bad_w;
   logic [ADDR_W-1:0] fixed_w;
   logic              lane_en;

   assign size = lsu_size_e'(acc_size);

   lsu_align_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
      .valid      (acc_valid),
      .size       (size),
      .addr       (acc_addr),
      .misaligned (mis_w),
      .size_bad   (bad_w),
      .addr_fixed (fixed_w)
   );

   assign lane_en = acc_valid && !bad_w;

   lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
      .en        (lane_en),
      .size      (size),
      .off       (fixed_w[OFF_W-1:0]),
      .wdata     (st_data),
      .be        (mem_be),
      .lane_data (mem_wdata)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_load (
      .size  (size),
      .sext  (acc_signed),
      .off   (fixed_w[OFF_W-1:0]),
      .rword (ld_word),
      .rdata (ld_data)
   );

   lsu_fault_log #(.ADDR_W(ADDR_W)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_fault   (mis_w && !acc_write),
      .wr_fault   (mis_w && acc_write),
      .clear      (fault_clear),
      .addr       (acc_addr),
      .fault_map  (fault_map),
      .fault_addr (fault_addr)
   );

   assign mem_addr = fixed_w;
   assign misalign = mis_w;
   assign size_err = acc_valid && bad_w;

   AST_IDLE_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (mem_be == '0) && !misalign && !size_err); // R11
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (acc_size == 2'd2) |-> mem_addr[OFF_W-1:0] == '0); // R5
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (acc_size == 2'd0) |-> $countones(mem_be) == 1); // R3
   AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (acc_size == 2'd1) |-> $countones(mem_be) == 2); // R2
   AST_BAD_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      size_err |-> (mem_be == '0) && !misalign); // R10

endmodule

// File: tb/be_lane_unit_tb.sv
`timescale 1ns/1ps
module be_lane_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic        acc_signed = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [31:0] st_data = '0;
   logic [31:0] ld_word = '0;
   logic        fault_clear = 1'b0;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] ld_data;
   logic        misalign;
   logic        size_err;
   logic [1:0]  fault_map;
   logic [31:0] fault_addr;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   be_lane_unit u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_size(acc_size), .acc_signed(acc_signed), .acc_addr(acc_addr),
      .st_data(st_data), .ld_word(ld_word), .fault_clear(fault_clear),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .ld_data(ld_data), .misalign(misalign), .size_err(size_err),
      .fault_map(fault_map), .fault_addr(fault_addr)
   );

   // ---------------- reference model ----------------
   logic [1:0]  m_map = 2'b00;
   logic [31:0] m_faddr = '0;

   function automatic logic [31:0] x_fix(input logic [1:0] sz, input logic [31:0] a);
      if (sz == 2'd2) return a & ~32'h3;
      if (sz == 2'd1) return a & ~32'h1;
      return a;
   endfunction

   function automatic logic x_mis(input logic v, input logic [1:0] sz, input logic [31:0] a);
      return v && ((sz == 2'd2 && a[1:0] != 2'b00) || (sz == 2'd1 && a[0]));
   endfunction

   function automatic logic [3:0] x_be(input logic v, input logic [1:0] sz, input logic [31:0] a);
      int off;
      off = int'(x_fix(sz, a) & 32'h3);
      if (!v || sz == 2'd3) return 4'h0;
      if (sz == 2'd0) return 4'h8 >> off;
      if (sz == 2'd1) return (off >= 2) ? 4'h3 : 4'hC;
      return 4'hF;
   endfunction

   function automatic logic [31:0] x_wd(input logic v, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] d);
      int off;
      off = int'(x_fix(sz, a) & 32'h3);
      if (!v || sz == 2'd3) return 32'h0;
      if (sz == 2'd0) return {24'h0, d[7:0]} << (8 * (3 - off));
      if (sz == 2'd1) return (off >= 2) ? {16'h0, d[15:0]} : {d[15:0], 16'h0};
      return d;
   endfunction

   function automatic logic [31:0] x_ld(input logic [1:0] sz, input logic sg,
                                        input logic [31:0] a, input logic [31:0] w);
      int off;
      logic [7:0] b;
      logic [15:0] h;
      off = int'(x_fix(sz, a) & 32'h3);
      b = 8'(w >> (8 * (3 - off)));
      h = (off >= 2) ? w[15:0] : w[31:16];
      case (sz)
         2'd0: return sg ? {{24{b[7]}}, b} : {24'h0, b};
         2'd1: return sg ? {{16{h[15]}}, h} : {16'h0, h};
         2'd2: return w;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_map   <= 2'b00;
         m_faddr <= '0;
      end else begin
         logic [1:0] nm;
         logic mis;
         mis = x_mis(acc_valid, acc_size, acc_addr);
         nm = fault_clear ? 2'b00 : m_map;
         if (mis && !acc_write) nm[0] = 1'b1;
         if (mis && acc_write)  nm[1] = 1'b1;
         m_map <= nm;
         if (mis) m_faddr <= acc_addr;
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string st_tag(input logic v, input logic [1:0] sz);
      if (!v) return "R11";
      case (sz)
         2'd0: return "R3";
         2'd1: return "R2";
         2'd2: return "R1";
         default: return "R10";
      endcase
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R12", "fault_map", {30'h0, fault_map}, 32'h0);
         chk("R12", "fault_addr", fault_addr, 32'h0);
      end else begin
         string t;
         t = st_tag(acc_valid, acc_size);
         chk(t, "mem_be", {28'h0, mem_be}, {28'h0, x_be(acc_valid, acc_size, acc_addr)});
         chk(t, "mem_wdata", mem_wdata, x_wd(acc_valid, acc_size, acc_addr, st_data));
         chk("R5", "mem_addr", mem_addr, x_fix(acc_size, acc_addr));
         chk(acc_valid ? "R4" : "R11", "misalign", {31'h0, misalign},
             {31'h0, x_mis(acc_valid, acc_size, acc_addr)});
         chk("R10", "size_err", {31'h0, size_err},
             {31'h0, (acc_valid && acc_size == 2'd3)});
         chk(acc_size == 2'd3 ? "R10" : "R9", "ld_data", ld_data,
             x_ld(acc_size, acc_signed, acc_addr, ld_word));
         chk("R6 R8", "fault_map", {30'h0, fault_map}, {30'h0, m_map});
         chk("R7", "fault_addr", fault_addr, m_faddr);
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic v, input logic w, input logic [1:0] sz,
                        input logic sg, input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] lw, input logic clr);
      @(negedge clk);
      #1;
      acc_valid = v; acc_write = w; acc_size = sz; acc_signed = sg;
      acc_addr = a; st_data = d; ld_word = lw; fault_clear = clr;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
      // R1 word store, R2 halfword both halves, R3 bytes at all offsets
      drive(1, 1, 2'd2, 0, 32'h0000_1000, 32'hDEAD_BEEF, 32'h0, 0);
      drive(1, 1, 2'd1, 0, 32'h0000_1000, 32'h1234_A5C3, 32'h0, 0);
      drive(1, 1, 2'd1, 0, 32'h0000_1002, 32'h1234_A5C3, 32'h0, 0);
      for (int o = 0; o < 4; o++)
         drive(1, 1, 2'd0, 0, 32'h0000_2000 + o, 32'h0000_00E7, 32'h0, 0);
      // R9 loads, signed and unsigned, every lane
      for (int o = 0; o < 4; o++) begin
         drive(1, 0, 2'd0, 1, 32'h0000_3000 + o, 32'h0, 32'h80FF_7F01, 0);
         drive(1, 0, 2'd0, 0, 32'h0000_3000 + o, 32'h0, 32'h80FF_7F01, 0);
      end
      drive(1, 0, 2'd1, 1, 32'h0000_3000, 32'h0, 32'h8001_F00F, 0);
      drive(1, 0, 2'd1, 0, 32'h0000_3002, 32'h0, 32'h8001_F00F, 0);
      drive(1, 0, 2'd1, 1, 32'h0000_3002, 32'h0, 32'h8001_F00F, 0);
      drive(1, 0, 2'd2, 1, 32'h0000_3004, 32'h0, 32'hCAFE_0123, 0);
      // R4 R5 R6 R7: misaligned read, then misaligned write, latest address wins
      drive(1, 0, 2'd2, 0, 32'h0000_4003, 32'h0, 32'h1122_3344, 0);
      drive(1, 1, 2'd1, 0, 32'h0000_5001, 32'h0000_BEEF, 32'h0, 0);
      drive(0, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 0);
      // R8 clear alone, then clear together with a new fault
      drive(0, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1);
      drive(1, 1, 2'd2, 0, 32'h0000_6002, 32'h5555_AAAA, 32'h0, 1);
      drive(0, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 0);
      // R10 unsupported size, R11 idle with a misaligned address
      drive(1, 1, 2'd3, 1, 32'h0000_7003, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
      drive(0, 1, 2'd2, 0, 32'h0000_7001, 32'hFFFF_FFFF, 32'h0, 0);
      drive(0, 0, 2'd1, 0, 32'h0000_7001, 32'h0, 32'h0, 0);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 8) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 2,
               $urandom, $urandom, $urandom, ($urandom % 6) == 0);
      end
      drive(0, 0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 0);
      @(negedge clk);
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule